// File: doc/BRIEF.md
# Three-Wire Tuning Control Word Receiver

This block takes 16-bit words from a host over three slow lines (a data line, a bit clock and an enable) and turns them into two registered 15-bit words for a tuning synthesizer. One word carries a frequency number. The other carries control fields: band select, reference step select, a four-bit pump gain, a gate bit, a load-mode bit, a two-bit detector mode, a receiver power-save bit and four test bits. All three lines are asynchronous to the system clock. Each line passes through a synchronizer, and its edges are detected in the system clock domain.

A frame is the set of bit-clock rising edges seen while the enable is high. The first bit says which word follows. A frame is only kept if it held exactly 16 bits. It is moved into its register by one further bit-clock rising edge after the enable has dropped. A frequency word is refused until a control word has arrived. When the power-save bit is set, the block raises a sleep indication after each transfer. The next frame, or a train of ten bit-clock pulses with the enable low, lowers it again.

The outputs are plain registers with no handshake. A transfer always succeeds, so there is no back-pressure. The host paces itself through the gap it leaves between frames.

Top module: `serial_tune_rx`

## Requirements
- R1: After reset, `freq_o` and `ctrl_o` are 0, `not_init_o` is 1 and `rx_sleep_o` is 0.
- R2: While `ser_en_i` is high, `ser_data_i` is sampled on each rising edge of `ser_clk_i`, MSB first. The first bit selects the word: 0 is a frequency word, 1 is a control word. The next 15 bits form the payload, with its bit 14 received first.
- R3: A frame that held any number of bits other than 16 is dropped, and neither register changes.
- R4: A transfer happens only on the first `ser_clk_i` rising edge after `ser_en_i` has fallen. Before that edge both registers hold their old values.
- R5: A control word copies its payload into `ctrl_o` and clears `not_init_o`. The bit layout is: 14 band, 13 reference step, 12:9 pump gain, 8 gate, 7 load mode, 6:5 detector mode, 4 power-save, 3:0 test.
- R6: When payload bit 8 (gate) of a control word is 0, `ctrl_o[7:0]` is loaded as 0 whatever was sent.
- R7: A frequency word received while `not_init_o` is 1 is ignored. Once a control word has been taken, a frequency word loads `freq_o`.
- R8: After each completed transfer, `rx_sleep_o` is set to the value of `ctrl_o[4]` as it stands after that transfer. A rising edge of `ser_en_i` clears it.
- R9: On the tenth `ser_clk_i` rising edge while `ser_en_i` stays low (the load edge counts), `rx_sleep_o` is cleared. Nine such edges leave it unchanged.
- R10: A register updates on the third system clock edge after the load edge is applied to `ser_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_en_i | input | 1 | Frame enable |
| freq_o | output | 15 | Frequency number register |
| ctrl_o | output | 15 | Control field register |
| not_init_o | output | 1 | High until a control word has been taken |
| rx_sleep_o | output | 1 | Receiver power-save indication |

## Verification
A line change reaches the detectors two system clocks after it is driven. The register acting on it updates on the third system clock edge. Outside the latency check, the bench holds each line level for four clocks and settles eight clocks after a load edge before it compares. The latency check drives the load edge at a falling clock edge. It then samples two nanoseconds after the second rising edge, where the old value is expected, and after the third, where the new value is expected.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int PAY_BITS  = 15;
  localparam int GATE_BIT  = 8;
  localparam int SLEEP_BIT = 4;
  localparam int GATED_W   = 8;
endpackage

// File: rtl/stw_sync.sv
module stw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/stw_framer.sv
module stw_framer #(
  parameter int WORD_W      = 16,
  parameter int INIT_PULSES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d,
  input  logic              c,
  input  logic              e,
  output logic [WORD_W-1:0] word,
  output logic              load_go,
  output logic              idle_hit,
  output logic              en_rise
);
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int IDLE_W = $clog2(INIT_PULSES + 1);

  logic              c_prev, e_prev, pend;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] idle;
  logic [WORD_W-1:0] sr;
  logic              c_rise, e_fall;

  assign c_rise   = c & ~c_prev;
  assign e_fall   = ~e & e_prev;
  assign en_rise  = e & ~e_prev;
  assign load_go  = ~e & c_rise & pend;
  assign idle_hit = ~e & c_rise & (idle == IDLE_W'(INIT_PULSES - 1));
  assign word     = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_prev <= 1'b0;
      e_prev <= 1'b0;
      pend   <= 1'b0;
      cnt    <= '0;
      idle   <= '0;
      sr     <= '0;
    end else begin
      c_prev <= c;
      e_prev <= e;
      if (en_rise) begin
        cnt  <= '0;
        idle <= '0;
        pend <= 1'b0;
      end
      if (e && c_rise) begin
        sr <= {sr[WORD_W-2:0], d};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
      if (e_fall) pend <= (cnt == CNT_W'(WORD_W));
      if (!e && c_rise) begin
        pend <= 1'b0;
        if (idle != IDLE_W'(INIT_PULSES)) idle <= idle + 1'b1;
      end
    end
  end

  // R3: a frame is only held for transfer when it counted exactly WORD_W bits
  assert_exact_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(cnt) == CNT_W'(WORD_W));
  // R4: transfers only ever occur with the enable low
  assert_load_en_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |-> !e && !$past(e_fall));
endmodule

// File: rtl/stw_latches.sv
module stw_latches #(
  parameter int WORD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_go,
  input  logic                         idle_hit,
  input  logic                         en_rise,
  input  logic [WORD_W-1:0]            word,
  output logic [stw_pkg::PAY_BITS-1:0] freq,
  output logic [stw_pkg::PAY_BITS-1:0] ctrl,
  output logic                         uninit,
  output logic                         sleep
);
  import stw_pkg::*;

  logic [PAY_BITS-1:0] b_val;

  always_comb begin
    b_val = word[PAY_BITS-1:0];
    if (!b_val[GATE_BIT]) b_val[GATED_W-1:0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq   <= '0;
      ctrl   <= '0;
      uninit <= 1'b1;
      sleep  <= 1'b0;
    end else if (load_go) begin
      if (word[WORD_W-1]) begin
        ctrl   <= b_val;
        uninit <= 1'b0;
        sleep  <= b_val[SLEEP_BIT];
      end else if (!uninit) begin
        freq  <= word[PAY_BITS-1:0];
        sleep <= ctrl[SLEEP_BIT];
      end
    end else if (en_rise || idle_hit) begin
      sleep <= 1'b0;
    end
  end

  // R7: frequency register never moves while uninitialised
  assert_freq_needs_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq) |-> !$past(uninit));
  // R6: gated low bits stay zero whenever gate bit is clear
  assert_gate_clears_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[GATE_BIT] |-> ctrl[GATED_W-1:0] == '0);
  // R8: sleep indication only while power-save bit is set
  assert_sleep_needs_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ctrl[SLEEP_BIT]);
  // R5: initialisation clears only on a transfer
  assert_init_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uninit) |-> $past(load_go));
endmodule

// File: rtl/serial_tune_rx.sv
module serial_tune_rx #(
  parameter int WORD_W      = 16,
  parameter int INIT_PULSES = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_data_i,
  input  logic        ser_clk_i,
  input  logic        ser_en_i,
  output logic [14:0] freq_o,
  output logic [14:0] ctrl_o,
  output logic        not_init_o,
  output logic        rx_sleep_o
);
  logic [2:0]        lines;
  logic              load_go, idle_hit, en_rise;
  logic [WORD_W-1:0] word;

  stw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ser_data_i, ser_clk_i, ser_en_i}), .dout(lines));

  stw_framer #(.WORD_W(WORD_W), .INIT_PULSES(INIT_PULSES)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .d(lines[2]), .c(lines[1]), .e(lines[0]),
    .word(word), .load_go(load_go), .idle_hit(idle_hit), .en_rise(en_rise));

  stw_latches #(.WORD_W(WORD_W)) u_lat (
    .clk(clk), .rst_n(rst_n),
    .load_go(load_go), .idle_hit(idle_hit), .en_rise(en_rise), .word(word),
    .freq(freq_o), .ctrl(ctrl_o), .uninit(not_init_o), .sleep(rx_sleep_o));
endmodule

// File: tb/sim_serial_tune_rx.sv
module sim_serial_tune_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
  logic [14:0] freq_o, ctrl_o;
  logic not_init_o, rx_sleep_o;
  int n_chk = 0, n_bad = 0;

  logic [14:0] m_freq = '0, m_ctrl = '0;
  logic        m_init = 1'b0, m_sleep = 1'b0, m_pend = 1'b0;
  logic [15:0] m_word = '0;
  int          m_idle = 0;

  always #2.5 clk = ~clk;

  serial_tune_rx u0 (.clk(clk), .rst_n(rst_n), .ser_data_i(ser_data),
    .ser_clk_i(ser_clk), .ser_en_i(ser_en), .freq_o(freq_o), .ctrl_o(ctrl_o),
    .not_init_o(not_init_o), .rx_sleep_o(rx_sleep_o));

  function automatic logic [14:0] gate_ctrl(logic [14:0] p);
    logic [14:0] r = p;
    if (!r[8]) r[7:0] = '0;
    return r;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "freq", 32'(freq_o), 32'(m_freq));
    chk(req, "ctrl", 32'(ctrl_o), 32'(m_ctrl));
    chk(req, "not_init", 32'(not_init_o), 32'(!m_init));
    chk(req, "sleep", 32'(rx_sleep_o), 32'(m_sleep));
  endtask

  task automatic bit_out(logic b);
    ser_data = b; tick(4); ser_clk = 1'b1; tick(4); ser_clk = 1'b0;
  endtask

  task automatic frame(logic [31:0] bits, int n);
    ser_en = 1'b1; tick(4);
    m_sleep = 1'b0; m_idle = 0; m_pend = 1'b0;
    for (int i = n - 1; i >= 0; i--) bit_out(bits[i]);
    tick(4); ser_en = 1'b0; tick(6);
    m_pend = (n == 16);
    m_word = bits[15:0];
  endtask

  task automatic model_pulse();
    if (m_idle < 10) m_idle++;
    if (m_pend) begin
      if (m_word[15]) begin
        m_ctrl = gate_ctrl(m_word[14:0]); m_init = 1'b1; m_sleep = m_ctrl[4];
      end else if (m_init) begin
        m_freq = m_word[14:0]; m_sleep = m_ctrl[4];
      end
      m_pend = 1'b0;
    end else if (m_idle == 10) m_sleep = 1'b0;
  endtask

  task automatic pulse();
    ser_clk = 1'b1; tick(4); ser_clk = 1'b0; tick(8);
    model_pulse();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    tick(4); rst_n = 1'b1; tick(4);
    chk_all("R1");

    // R7: frequency word before any control word is ignored
    frame({16'h0, 1'b0, 15'h1234}, 16); pulse(); chk_all("R7");

    // R5/R6: control word with gate clear drops low byte
    frame({16'h0, 1'b1, 15'h7EFF}, 16); pulse(); chk_all("R6");
    chk("R6", "low byte", 32'(ctrl_o[7:0]), 32'h0);
    // R5/R2: control word with gate set, all fields kept
    frame({16'h0, 1'b1, 15'h5BA5}, 16); pulse(); chk_all("R5");
    chk("R2", "ctrl layout", 32'(ctrl_o), 32'h5BA5);

    // R4: no transfer before load edge
    frame({16'h0, 1'b0, 15'h2AAA}, 16);
    chk("R4", "freq before load", 32'(freq_o), 32'(m_freq));
    pulse(); chk_all("R7");
    chk("R2", "freq value", 32'(freq_o), 32'h2AAA);

    // R3: 15 and 17 bit frames discarded
    frame({17'h0, 15'h0111}, 15); pulse(); chk_all("R3");
    frame({15'h0, 1'b0, 1'b0, 15'h3333}, 17); pulse(); chk_all("R3");

    // R10: latency of a transfer
    frame({16'h0, 1'b0, 15'h4C21}, 16);
    ser_clk = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    chk("R10", "freq early", 32'(freq_o), 32'(m_freq));
    @(posedge clk); #2;
    chk("R10", "freq due", 32'(freq_o), 32'h4C21);
    @(negedge clk); tick(3); ser_clk = 1'b0; tick(8);
    model_pulse(); chk_all("R10");

    // R8: power-save bit set, sleep after transfer; next frame clears it
    frame({16'h0, 1'b1, 15'h0110}, 16); pulse(); chk_all("R8");
    chk("R8", "sleep set", 32'(rx_sleep_o), 32'h1);
    ser_en = 1'b1; tick(8); m_sleep = 1'b0;
    chk("R8", "sleep after en rise", 32'(rx_sleep_o), 32'h0);
    ser_en = 1'b0; tick(8);
    frame({16'h0, 1'b0, 15'h0077}, 16); pulse(); chk_all("R8");

    // R9: 9 edges keep sleep, 10th clears it
    for (int i = 0; i < 8; i++) pulse();
    chk("R9", "sleep after 9", 32'(rx_sleep_o), 32'h1);
    pulse(); chk("R9", "sleep after 10", 32'(rx_sleep_o), 32'h0);
    chk_all("R9");

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [31:0] v;
      int n;
      v = $urandom();
      n = ($urandom() % 4 == 0) ? 15 + int'($urandom() % 3) : 16;
      frame(v, n); pulse();
      chk_all(n == 16 ? (v[15] ? "R5" : "R7") : "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule